// File: doc/BRIEF.md
# Predicated Load-and-Replicate Vector Unit

The unit executes a single contiguous vector load that reads up to four 64-bit elements from memory under a four-lane predicate. It packs them into one 256-bit chunk and copies that chunk into every complete 256-bit segment of a scalable destination vector. The caller presents a 32-bit instruction word, a general-register base value, the stack pointer, a predicate word and the configured vector length in a single `start_i` cycle. The unit then issues one 64-bit read at a time over a valid/ready request channel and a response channel.

The unit decodes and validates the instruction word first. It then chooses the base value, forms the element addresses from the base plus a scaled signed immediate, and skips inactive lanes. Inactive lanes cause no read and no fault. The unit ends each operation with exactly one of three one-cycle pulses: a completion pulse with the full-width result, an undefined-instruction flag, or a stack-alignment fault.

Top module: `ld_rep_unit`

## Requirements
- R1: An instruction word is accepted only if bits [31:20] equal 12'b101001011010 and bits [15:13] equal 3'b001. Any other word raises `undef_o` one cycle after `start_i` and issues no memory request. Field layout: imm4 [19:16], predicate register index [12:10], base register index [9:5], destination index [4:0].
- R2: `vl_i` counts 128-bit granules. A value below 2 (vector length under 256 bits) raises `undef_o` one cycle after `start_i` and issues no request.
- R3: The address of element e (0..3) is base + sign_extend(imm4)*32 + 8*e, computed modulo 2^64. The offset therefore spans -256 to +224.
- R4: A read is requested only for element e whose predicate bit `pred_i[e]` is set, with e from 0 to 3. Requests go out in ascending element order, and predicate bits 4 and above have no effect.
- R5: Each inactive element reads as zero in the 256-bit chunk. Active element e occupies chunk bits [64e+63:64e] and takes the returned data.
- R6: The chunk is copied into result segment s (bits [256s+255:256s]) when 2*(s+1) <= `vl_i`. All other result bits are zero, including a trailing partial 128-bit granule and everything above the vector length.
- R7: A base register index of 31 selects `sp_i` as the base. Any other index selects `base_gpr_i`.
- R8: If the base register index is 31, at least one of lanes 0..3 is active and `sp_i[3:0]` is nonzero, the unit raises `align_fault_o` one cycle after `start_i` and issues no request. With no active lane, a misaligned stack pointer is not checked.
- R9: `done_o` pulses for one cycle on the cycle after the last active read response is accepted. When no lane is active, it pulses on the cycle after `start_i`. `result_o` and `dst_idx_o` are valid while it is high.
- R10: While `req_valid_o` is high and `req_ready_i` is low, the request stays asserted with an unchanged address.
- R11: At most one read is outstanding at a time. No new request is raised until the previous one has received its response.
- R12: `undef_o` takes priority over `align_fault_o`. Exactly one of `done_o`, `undef_o` or `align_fault_o` pulses per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation (honoured when not busy) |
| insn_i | input | 32 | Instruction word |
| base_gpr_i | input | 64 | General-register base value |
| sp_i | input | 64 | Stack pointer value |
| pred_i | input | 32 | Predicate word; bit e governs element e |
| vl_i | input | 5 | Vector length in 128-bit granules (1..16) |
| pg_idx_o | output | 3 | Predicate register index decoded from `insn_i` (combinational) |
| busy_o | output | 1 | Operation in progress |
| req_valid_o | output | 1 | Read request valid |
| req_addr_o | output | 64 | Read request byte address |
| req_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data |
| done_o | output | 1 | Completion pulse |
| result_o | output | 2048 | Replicated result vector |
| dst_idx_o | output | 5 | Destination register index of the completed load |
| undef_o | output | 1 | Undefined-instruction pulse |
| align_fault_o | output | 1 | Stack-alignment fault pulse |

## Verification
The stimulus mixes random and directed predicate masks. The all-clear mask and a mask with only bits above lane 3 set separate "no access, immediate completion" from lane skipping. Sparse masks expose ordering and zero-fill errors. Vector lengths of 1, 2, 3 and 16 granules separate the undefined case, the single-segment case, the case with a trailing half segment cleared, and full replication. Immediates of -8 and +7 with bases near zero and near 2^64 exercise sign extension and wrap-around. Stack-pointer bases, aligned and misaligned, with and without active lanes, tell the alignment fault apart from the general-register path and from the case where no lane is active.

// File: rtl/ld_rep_pkg.sv
package ld_rep_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned ELEM_W   = 64;
  localparam int unsigned CHUNK_W  = LANES * ELEM_W;
  localparam int unsigned LANE_W   = $clog2(LANES);
  localparam logic [11:0] OPC_HI   = 12'b1010_0101_1010;
  localparam logic [2:0]  OPC_MID  = 3'b001;
  localparam logic [4:0]  SP_IDX   = 5'd31;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  typedef struct packed {
    logic       enc_ok;
    logic [3:0] imm;
    logic [2:0] pg;
    logic [4:0] rn;
    logic [4:0] zt;
  } dec_t;

  // first active lane at or above 'from'; returns {found, idx}
  function automatic logic [LANE_W:0] first_from(input logic [LANES-1:0] mask,
                                                 input logic [LANE_W:0] from);
    logic [LANE_W:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) r = {1'b1, LANE_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/ld_rep_decode.sv
module ld_rep_decode
  import ld_rep_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.enc_ok = (insn_i[31:20] == OPC_HI) && (insn_i[15:13] == OPC_MID);
    dec_o.imm    = insn_i[19:16];
    dec_o.pg     = insn_i[12:10];
    dec_o.rn     = insn_i[9:5];
    dec_o.zt     = insn_i[4:0];
  end
endmodule

// File: rtl/ld_rep_agu.sv
module ld_rep_agu
  import ld_rep_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [3:0]        imm_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BYTE_SH = $clog2(ELEM_W / 8);
  localparam int unsigned IMM_SH  = $clog2(CHUNK_W / 8);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] lane_off;
  assign off      = {{(ADDR_W-4-IMM_SH){imm_i[3]}}, imm_i, {IMM_SH{1'b0}}};
  assign lane_off = {{(ADDR_W-LANE_W-BYTE_SH){1'b0}}, lane_i, {BYTE_SH{1'b0}}};
  assign addr_o   = base_i + off + lane_off; // wraps mod 2^ADDR_W
endmodule

// File: rtl/ld_rep_replicate.sv
module ld_rep_replicate
  import ld_rep_pkg::*;
#(
  parameter int unsigned VL_MAX = 2048,
  parameter int unsigned VL_GW  = 5
) (
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic [VL_GW-1:0]   vl_gran_i,
  output logic [VL_MAX-1:0]  vec_o
);
  localparam int unsigned NSEG     = VL_MAX / CHUNK_W;
  localparam int unsigned GR_PER_S = CHUNK_W / 128;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam logic [VL_GW:0] NEED = (VL_GW+1)'(GR_PER_S * (s + 1));
    assign vec_o[s*CHUNK_W +: CHUNK_W] =
      ({1'b0, vl_gran_i} >= NEED) ? chunk_i : '0;
  end
endmodule

// File: rtl/ld_rep_unit.sv
module ld_rep_unit
  import ld_rep_pkg::*;
#(
  parameter int unsigned VL_MAX = 2048,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned PRED_W = VL_MAX / 64,
  parameter int unsigned VL_GW  = $clog2(VL_MAX / 128) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [31:0]         insn_i,
  input  logic [ADDR_W-1:0]   base_gpr_i,
  input  logic [ADDR_W-1:0]   sp_i,
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [VL_GW-1:0]    vl_i,
  output logic [2:0]          pg_idx_o,
  output logic                busy_o,
  output logic                req_valid_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  input  logic                req_ready_i,
  input  logic                rsp_valid_i,
  input  logic [ELEM_W-1:0]   rsp_data_i,
  output logic                done_o,
  output logic [VL_MAX-1:0]   result_o,
  output logic [4:0]          dst_idx_o,
  output logic                undef_o,
  output logic                align_fault_o
);
  localparam logic [VL_GW-1:0] MIN_GRAN = VL_GW'(CHUNK_W / 128);

  dec_t              dec;
  state_e            state_q;
  logic [ADDR_W-1:0] base_q;
  logic [3:0]        imm_q;
  logic [LANES-1:0]  mask_q;
  logic [VL_GW-1:0]  vl_q;
  logic [LANE_W-1:0] lane_q;
  logic [CHUNK_W-1:0] chunk_q, chunk_nxt;
  logic [VL_MAX-1:0] rep_vec;
  logic              done_q, undef_q, fault_q;
  logic [VL_MAX-1:0] result_q;
  logic [4:0]        dst_q;

  logic [LANES-1:0]  mask_in;
  logic              is_undef, is_fault;
  logic [LANE_W:0]   first_hit, next_hit;
  logic              unused_pred;

  assign unused_pred = ^pred_i[PRED_W-1:LANES];

  ld_rep_decode i_dec (.insn_i(insn_i), .dec_o(dec));

  ld_rep_agu #(.ADDR_W(ADDR_W)) i_agu (
    .base_i(base_q), .imm_i(imm_q), .lane_i(lane_q), .addr_o(req_addr_o)
  );

  ld_rep_replicate #(.VL_MAX(VL_MAX), .VL_GW(VL_GW)) i_rep (
    .chunk_i(chunk_nxt), .vl_gran_i(vl_q), .vec_o(rep_vec)
  );

  assign mask_in   = pred_i[LANES-1:0];
  assign is_undef  = !dec.enc_ok || (vl_i < MIN_GRAN);
  assign is_fault  = (dec.rn == SP_IDX) && (|mask_in) && (|sp_i[3:0]);
  assign first_hit = first_from(mask_in, '0);
  assign next_hit  = first_from(mask_q, {1'b0, lane_q} + 1'b1);

  always_comb begin
    chunk_nxt = chunk_q;
    if (state_q == ST_WAIT && rsp_valid_i)
      chunk_nxt[lane_q*ELEM_W +: ELEM_W] = rsp_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      imm_q    <= '0;
      mask_q   <= '0;
      vl_q     <= '0;
      lane_q   <= '0;
      chunk_q  <= '0;
      done_q   <= 1'b0;
      undef_q  <= 1'b0;
      fault_q  <= 1'b0;
      result_q <= '0;
      dst_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= (dec.rn == SP_IDX) ? sp_i : base_gpr_i;
          imm_q   <= dec.imm;
          mask_q  <= mask_in;
          vl_q    <= vl_i;
          chunk_q <= '0;
          lane_q  <= first_hit[LANE_W-1:0];
          if (is_undef)        undef_q <= 1'b1;
          else if (is_fault)   fault_q <= 1'b1;
          else if (!first_hit[LANE_W]) begin
            done_q   <= 1'b1;
            result_q <= '0;
            dst_q    <= dec.zt;
          end else begin
            dst_q   <= dec.zt;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          chunk_q <= chunk_nxt;
          if (next_hit[LANE_W]) begin
            lane_q  <= next_hit[LANE_W-1:0];
            state_q <= ST_REQ;
          end else begin
            result_q <= rep_vec;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pg_idx_o      = dec.pg;
  assign busy_o        = (state_q != ST_IDLE);
  assign req_valid_o   = (state_q == ST_REQ);
  assign done_o        = done_q;
  assign undef_o       = undef_q;
  assign align_fault_o = fault_q;
  assign result_o      = result_q;
  assign dst_idx_o     = dst_q;

  a_r4_active_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> mask_q[lane_q]);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, undef_o, align_fault_o}));
  a_r1_r2_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !req_valid_o);
  a_r8_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> !req_valid_o);
endmodule

// File: tb/test_ld_rep_unit.sv
module test_ld_rep_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VL_MAX = 2048;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] insn = '0;
  logic [63:0] gpr = '0, sp = '0;
  logic [31:0] pred = '0;
  logic [4:0]  vl = '0;
  logic [2:0]  pg_idx;
  logic busy, req_valid, req_ready = 0, rsp_valid = 0;
  logic [63:0] req_addr, rsp_data = '0;
  logic done, undef, fault;
  logic [VL_MAX-1:0] result;
  logic [4:0] dst_idx;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_rep_unit i_ld_rep_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn),
    .base_gpr_i(gpr), .sp_i(sp), .pred_i(pred), .vl_i(vl),
    .pg_idx_o(pg_idx), .busy_o(busy),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_ready_i(req_ready),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .done_o(done), .result_o(result), .dst_idx_o(dst_idx),
    .undef_o(undef), .align_fault_o(fault)
  );

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [3:0] imm, input logic [2:0] pg,
                                          input logic [4:0] rn, input logic [4:0] zt);
    return {12'b1010_0101_1010, imm, 3'b001, pg, rn, zt};
  endfunction

  function automatic logic [VL_MAX-1:0] exp_vec(input logic [255:0] ch, input int g);
    logic [VL_MAX-1:0] r = '0;
    for (int s = 0; s < VL_MAX/256; s++)
      if (g >= 2*(s+1)) r[s*256 +: 256] = ch;
    return r;
  endfunction

  // kind: 0 done, 1 undef, 2 fault
  task automatic run_op(input logic [31:0] in_w, input logic [63:0] g,
                        input logic [63:0] s, input logic [31:0] p, input int vlg,
                        input int lat_max);
    bit ex_undef, ex_fault, enc_ok, must_end;
    logic [63:0] base, a0;
    logic [63:0] ex_addr[4];
    logic [255:0] ex_chunk = '0;
    int ex_n = 0, got_n = 0, cyc = 0, kind_exp, kind_got;
    enc_ok   = (in_w[31:20] == 12'b1010_0101_1010) && (in_w[15:13] == 3'b001);
    ex_undef = !enc_ok || (vlg < 2);
    ex_fault = !ex_undef && (in_w[9:5] == 5'd31) && (|p[3:0]) && (|s[3:0]);
    base = (in_w[9:5] == 5'd31) ? s : g;                         // R7
    a0   = base + {{55{in_w[19]}}, in_w[19:16], 5'b0};            // R3
    for (int e = 0; e < 4; e++)
      if (p[e] && !ex_undef && !ex_fault) begin
        ex_addr[ex_n] = a0 + 64'(e*8);
        ex_chunk[e*64 +: 64] = mem_word(ex_addr[ex_n]);           // R5
        ex_n++;
      end
    kind_exp = ex_undef ? 1 : (ex_fault ? 2 : 0);
    @(negedge clk);
    insn = in_w; gpr = g; sp = s; pred = p; vl = 5'(vlg); start = 1;
    @(negedge clk);
    start = 0;
    must_end = (ex_n == 0);
    while (1) begin
      if (done || undef || fault) break;
      check(!must_end, "R9", $sformatf("no outcome when due; expected kind %0d", kind_exp));
      if (must_end || cyc > 400) break;
      if (req_valid && ($urandom % 3 != 0)) begin
        req_ready = 1;
        if (got_n < ex_n)
          check(req_addr == ex_addr[got_n], "R3", $sformatf("req %0d addr %h exp %h",
                got_n, req_addr, ex_addr[got_n]));
        else
          check(0, "R4", $sformatf("extra request addr %h, exp %0d reqs", req_addr, ex_n));
        got_n++;
        @(negedge clk);
        req_ready = 0;
        repeat ($urandom % (lat_max + 1)) begin
          check(!req_valid, "R11", "request raised while read outstanding, exp none");
          @(negedge clk);
        end
        rsp_valid = 1;
        rsp_data  = mem_word(req_addr);
        @(negedge clk);
        rsp_valid = 0;
        if (got_n >= ex_n) must_end = 1;
        cyc++;
        continue;
      end
      @(negedge clk);
      cyc++;
    end
    kind_got = done ? 0 : (undef ? 1 : (fault ? 2 : 3));
    check(kind_got == kind_exp, "R12", $sformatf("outcome %0d exp %0d", kind_got, kind_exp));
    check(got_n == ex_n, "R4", $sformatf("reqs %0d exp %0d", got_n, ex_n));
    if (done) begin
      logic [VL_MAX-1:0] ev = exp_vec(ex_chunk, vlg);
      check(result == ev, "R6", $sformatf("result low %h exp %h", result[511:0], ev[511:0]));
      check(dst_idx == in_w[4:0], "R9", $sformatf("dst %0d exp %0d", dst_idx, in_w[4:0]));
    end
    @(negedge clk);
    check(!done && !undef && !fault, "R9", $sformatf("outcome pulse held: %b%b%b exp 000",
          done, undef, fault));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!req_valid && !done && !undef && !fault && !busy && result == '0, "R9",
          "reset state not idle/zero, exp idle");
    rst_n = 1;
    @(negedge clk);
    check(pg_idx == 3'd0, "R1", $sformatf("pg_idx %0d exp 0", pg_idx));
    insn = mk_insn(4'd0, 3'd5, 5'd1, 5'd2);
    #1 check(pg_idx == 3'd5, "R1", $sformatf("pg_idx %0d exp 5", pg_idx));
    // R1 bad encodings
    run_op(mk_insn(4'd1, 3'd0, 5'd3, 5'd4) ^ 32'h8000_0000, 64'h1000, 64'h0, 32'hF, 4, 1);
    run_op(mk_insn(4'd1, 3'd0, 5'd3, 5'd4) ^ 32'h0000_4000, 64'h1000, 64'h0, 32'hF, 4, 1);
    // R2 short vector
    run_op(mk_insn(4'd0, 3'd1, 5'd3, 5'd4), 64'h2000, 64'h0, 32'hF, 1, 1);
    // R6 exact single segment, trailing half, full
    run_op(mk_insn(4'd0, 3'd1, 5'd3, 5'd7), 64'h3000, 64'h0, 32'hF, 2, 1);
    run_op(mk_insn(4'd2, 3'd1, 5'd3, 5'd7), 64'h3000, 64'h0, 32'h5, 3, 2);
    run_op(mk_insn(4'd1, 3'd1, 5'd3, 5'd7), 64'h3000, 64'h0, 32'hA, 16, 0);
    // R4 no lanes / only high bits
    run_op(mk_insn(4'd0, 3'd1, 5'd3, 5'd9), 64'h4000, 64'h0, 32'h0, 8, 1);
    run_op(mk_insn(4'd0, 3'd1, 5'd3, 5'd9), 64'h4000, 64'h0, 32'hFFFF_FFF0, 8, 1);
    run_op(mk_insn(4'd0, 3'd1, 5'd3, 5'd9), 64'h4000, 64'h0, 32'hFFFF_FFF8, 8, 1);
    // R3 wrap with -256 and +224
    run_op(mk_insn(4'h8, 3'd0, 5'd2, 5'd1), 64'h40, 64'h0, 32'hF, 16, 1);
    run_op(mk_insn(4'h7, 3'd0, 5'd2, 5'd1), 64'hFFFF_FFFF_FFFF_FF30, 64'h0, 32'hF, 16, 1);
    // R7 / R8 stack pointer base
    run_op(mk_insn(4'h3, 3'd2, 5'd31, 5'd6), 64'hDEAD_0000, 64'h8000_0000, 32'h9, 6, 1);
    run_op(mk_insn(4'h3, 3'd2, 5'd31, 5'd6), 64'hDEAD_0000, 64'h8000_0008, 32'h9, 6, 1);
    run_op(mk_insn(4'h3, 3'd2, 5'd31, 5'd6), 64'hDEAD_0000, 64'h8000_0008, 32'h10, 6, 1);
    // R12 undef over fault
    run_op(mk_insn(4'h3, 3'd2, 5'd31, 5'd6), 64'h0, 64'h8000_0004, 32'hF, 1, 1);
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      logic [63:0] sv;
      w = mk_insn(4'($urandom), 3'($urandom), ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 31),
                  5'($urandom));
      if ($urandom % 10 == 0) w = w ^ (32'h1 << (($urandom % 2) ? 20 + $urandom % 12
                                                              : 13 + $urandom % 3));
      sv = {$urandom, $urandom};
      if ($urandom % 2) sv[3:0] = 4'h0;
      run_op(w, {$urandom, $urandom}, sv, $urandom, 1 + $urandom % 16, 3);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule